// File: doc/BRIEF.md
# Pixel Padding Lane Chain

This block widens an ALU adder so that, besides an ordinary add, it can fill the empty pixels of one image line in a single issue. The operand word holds N_LANES 8-bit pixels. A mask holds one bit per pixel, set where the pixel belongs to the object. Any pixel outside the object takes the value of the closest object pixel found to its left or to its right. When object pixels lie on both sides, it takes the rounded-down average of the two. A chain of propagation nodes carries the nearest object value in each direction. A shared set of byte adders then forms the sum or the average.

Two 9-bit edge inputs feed the outer ends of the chain, so a line wider than the word can be continued from a neighbouring word. The result is the padded word plus a widened mask. The mask marks every pixel that is now filled.

The block has two register stages and accepts one operation per clock. With padding off, it returns the plain sum of the two operands, with carries running across all bytes.

Top module: `pixel_pad_alu`

## Requirements
- R1: A synchronous active-high reset clears both result outputs to zero. They stay zero while reset is held.
- R2: An operation presented before a rising edge appears on the outputs after the second rising edge. A new operation can be accepted every cycle.
- R3: With `pad_en` low, `res_out` is (`op_a` + `op_b`) modulo 2^(8·N_LANES), with carries across every byte. `shape_out` equals `shape_in`.
- R4: Lane k occupies `op_a`/`res_out` bits [8k+7:8k], and its mask bit is bit k. Lane 0 is the leftmost pixel of the line. In padding mode, a lane whose mask bit is 1 keeps its pixel unchanged.
- R5: In padding mode, a lane with mask bit 0 that has no object pixel on either side, counting the edge inputs, keeps its own original pixel value.
- R6: In padding mode, a lane with mask bit 0 that has an object pixel on exactly one side takes the value of the nearest object pixel on that side.
- R7: In padding mode, a lane with mask bit 0 that has object pixels on both sides takes floor((L+R)/2) of the two nearest values. The sum is formed with 9 bits, so nothing overflows.
- R8: Each edge input uses bit 8 as its object flag and bits 7:0 as its pixel. `bnd_left` lies just left of lane 0 and `bnd_right` just right of lane N_LANES-1. When bit 8 of an edge input is 0, its pixel bits have no effect.
- R9: In padding mode, bit k of `shape_out` is 1 exactly when lane k is an object pixel or has an object pixel, or a flagged edge input, on at least one side.
- R10: In padding mode, `op_b` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_en | input | 1 | 1 selects line padding, 0 selects plain add |
| op_a | input | 8·N_LANES | Pixel word, or first addend |
| op_b | input | 8·N_LANES | Second addend (used only for plain add) |
| shape_in | input | N_LANES | Object mask, one bit per lane |
| bnd_left | input | 9 | Left edge token {object flag, pixel} |
| bnd_right | input | 9 | Right edge token {object flag, pixel} |
| res_out | output | 8·N_LANES | Padded word or sum |
| shape_out | output | N_LANES | Updated mask |

## Verification
The bench builds the block with eight lanes. At that width every one of the 256 possible masks can be swept in padding mode, each with random pixels and random edge tokens, so all gap shapes occur: leading gaps, trailing gaps, interior gaps and the fully empty line. Directed words cover the carry running across the whole 64-bit add, averages at the 0xFF limit, and edge tokens whose flag is clear but whose pixel is not zero. A random stream mixes both modes back to back, which exercises the two-cycle pipeline under continuous issue.

// File: rtl/pad_pkg.sv
`timescale 1ns/1ps
package pad_pkg;

    localparam int PIX_W = 8;

    // Token moving along the chain: object flag on top, pixel below.
    typedef struct packed {
        logic             obj;
        logic [PIX_W-1:0] pix;
    } pad_tok_t;

    typedef enum logic [1:0] {
        SEL_ADD  = 2'd0,
        SEL_KEEP = 2'd1,
        SEL_SUM  = 2'd2,
        SEL_AVG  = 2'd3
    } pad_sel_e;

    // Chooses what a lane's result is built from.
    function automatic pad_sel_e pad_select(input logic pad, input logic own,
                                            input logic nb_l, input logic nb_r);
        if (!pad)              return SEL_ADD;
        if (own)               return SEL_KEEP;
        if (nb_l && nb_r)      return SEL_AVG;
        if (nb_l || nb_r)      return SEL_SUM;
        return SEL_KEEP;
    endfunction

endpackage

// File: rtl/pad_prop_chain.sv
`timescale 1ns/1ps
module pad_prop_chain
    import pad_pkg::*;
#(
    parameter int N_LANES = 8
) (
    input  logic [N_LANES*PIX_W-1:0] pix,
    input  logic [N_LANES-1:0]       shp,
    input  pad_tok_t                 edge_l,
    input  pad_tok_t                 edge_r,
    output pad_tok_t [N_LANES-1:0]   from_left,
    output pad_tok_t [N_LANES-1:0]   from_right
);

    // Rightward pass: each lane sees the nearest object token on its left.
    always_comb begin : rightward
        pad_tok_t run;
        run = edge_l.obj ? edge_l : '0;
        for (int k = 0; k < N_LANES; k++) begin
            from_left[k] = run;
            if (shp[k]) run = '{obj: 1'b1, pix: pix[k*PIX_W +: PIX_W]};
        end
    end

    // Leftward pass: each lane sees the nearest object token on its right.
    always_comb begin : leftward
        pad_tok_t run;
        run = edge_r.obj ? edge_r : '0;
        for (int k = N_LANES-1; k >= 0; k--) begin
            from_right[k] = run;
            if (shp[k]) run = '{obj: 1'b1, pix: pix[k*PIX_W +: PIX_W]};
        end
    end

    // R5/R8: an empty line with unflagged edges carries nothing along the chain.
    always_comb begin
        if (shp == '0 && !edge_l.obj && !edge_r.obj)
            a_r5_empty_line: assert (from_left == '0 && from_right == '0);
    end

endmodule

// File: rtl/pad_byte_unit.sv
`timescale 1ns/1ps
module pad_byte_unit
    import pad_pkg::*;
(
    input  pad_sel_e         sel,
    input  logic             carry_en,
    input  logic [PIX_W-1:0] opnd_a,
    input  logic [PIX_W-1:0] opnd_b,
    input  logic [PIX_W-1:0] pix,
    input  logic             cin,
    output logic [PIX_W-1:0] res,
    output logic             cout
);

    logic [PIX_W:0] sum;

    assign sum  = {1'b0, opnd_a} + {1'b0, opnd_b} + {{PIX_W{1'b0}}, cin & carry_en};
    assign cout = sum[PIX_W];

    always_comb begin
        unique case (sel)
            SEL_ADD,
            SEL_SUM:  res = sum[PIX_W-1:0];
            SEL_KEEP: res = pix;
            SEL_AVG:  res = sum[PIX_W:1];
            default:  res = sum[PIX_W-1:0];
        endcase
    end

    logic [PIX_W-1:0] lo_v, hi_v;
    assign lo_v = (opnd_a < opnd_b) ? opnd_a : opnd_b;
    assign hi_v = (opnd_a < opnd_b) ? opnd_b : opnd_a;

    // R7: an average never leaves the interval spanned by its two inputs.
    always_comb begin
        if (sel == SEL_AVG)
            a_r7_avg_between: assert (res >= lo_v && res <= hi_v);
    end

endmodule

// File: rtl/pixel_pad_alu.sv
`timescale 1ns/1ps
module pixel_pad_alu
    import pad_pkg::*;
#(
    parameter int N_LANES = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pad_en,
    input  logic [N_LANES*PIX_W-1:0]   op_a,
    input  logic [N_LANES*PIX_W-1:0]   op_b,
    input  logic [N_LANES-1:0]         shape_in,
    input  logic [PIX_W:0]             bnd_left,
    input  logic [PIX_W:0]             bnd_right,
    output logic [N_LANES*PIX_W-1:0]   res_out,
    output logic [N_LANES-1:0]         shape_out
);

    localparam int WORD_W = N_LANES * PIX_W;

    // ---------------- stage 1: propagation and operand select ----------------
    pad_tok_t [N_LANES-1:0] from_left, from_right;

    pad_prop_chain #(.N_LANES(N_LANES)) chain_i (
        .pix        (op_a),
        .shp        (shape_in),
        .edge_l     (pad_tok_t'(bnd_left)),
        .edge_r     (pad_tok_t'(bnd_right)),
        .from_left  (from_left),
        .from_right (from_right)
    );

    logic [WORD_W-1:0]  a_d, b_d;
    logic [N_LANES-1:0] nl_d, nr_d;

    always_comb begin
        for (int k = 0; k < N_LANES; k++) begin
            a_d[k*PIX_W +: PIX_W] = pad_en ? from_right[k].pix : op_a[k*PIX_W +: PIX_W];
            b_d[k*PIX_W +: PIX_W] = pad_en ? from_left[k].pix  : op_b[k*PIX_W +: PIX_W];
            nl_d[k] = pad_en & from_left[k].obj;
            nr_d[k] = pad_en & from_right[k].obj;
        end
    end

    logic               s1_pad;
    logic [WORD_W-1:0]  s1_a, s1_b, s1_pix;
    logic [N_LANES-1:0] s1_shp, s1_nl, s1_nr;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_pad <= 1'b0;
            s1_a   <= '0;
            s1_b   <= '0;
            s1_pix <= '0;
            s1_shp <= '0;
            s1_nl  <= '0;
            s1_nr  <= '0;
        end else begin
            s1_pad <= pad_en;
            s1_a   <= a_d;
            s1_b   <= b_d;
            s1_pix <= op_a;
            s1_shp <= shape_in;
            s1_nl  <= nl_d;
            s1_nr  <= nr_d;
        end
    end

    // ---------------- stage 2: byte adders and result select ----------------
    logic [N_LANES:0]   cy;
    logic [WORD_W-1:0]  res_d;
    logic [N_LANES-1:0] shape_d;

    assign cy[0] = 1'b0;

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        pad_byte_unit byte_i (
            .sel      (pad_select(s1_pad, s1_shp[k], s1_nl[k], s1_nr[k])),
            .carry_en (~s1_pad),
            .opnd_a   (s1_a[k*PIX_W +: PIX_W]),
            .opnd_b   (s1_b[k*PIX_W +: PIX_W]),
            .pix      (s1_pix[k*PIX_W +: PIX_W]),
            .cin      (cy[k]),
            .res      (res_d[k*PIX_W +: PIX_W]),
            .cout     (cy[k+1])
        );

        // R4: an object lane leaves padding with its pixel untouched.
        a_r4_keep_obj: assert property (@(posedge clk) disable iff (rst)
            ($past(s1_pad) && $past(s1_shp[k]))
            |-> res_out[k*PIX_W +: PIX_W] == $past(s1_pix[k*PIX_W +: PIX_W]));
    end

    assign shape_d = s1_pad ? (s1_shp | s1_nl | s1_nr) : s1_shp;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_out   <= '0;
            shape_out <= '0;
        end else begin
            res_out   <= res_d;
            shape_out <= shape_d;
        end
    end

    // R3: with padding off the byte units form one full-width adder.
    always_comb begin
        if (!s1_pad)
            a_r3_carry_chain: assert ({cy[N_LANES], res_d} == {1'b0, s1_a} + {1'b0, s1_b});
    end

    // R9: padding only ever adds bits to the mask.
    a_r9_shape_grow: assert property (@(posedge clk) disable iff (rst)
        $past(s1_pad) |-> (shape_out & $past(s1_shp)) == $past(s1_shp));

endmodule

// File: tb/pixel_pad_alu_tb_top.sv
`timescale 1ns/1ps
module pixel_pad_alu_tb_top;

    localparam int NL = 8;
    localparam int W  = NL * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pad_en = 1'b0;
    logic [W-1:0]  op_a = '0, op_b = '0;
    logic [NL-1:0] shape_in = '0;
    logic [8:0]    bnd_left = '0, bnd_right = '0;
    logic [W-1:0]  res_out;
    logic [NL-1:0] shape_out;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    pixel_pad_alu #(.N_LANES(NL)) dut_i (
        .clk(clk), .rst(rst), .pad_en(pad_en), .op_a(op_a), .op_b(op_b),
        .shape_in(shape_in), .bnd_left(bnd_left), .bnd_right(bnd_right),
        .res_out(res_out), .shape_out(shape_out)
    );

    // Reference model: explicit search for the nearest object on each side.
    function automatic void pad_model(input logic pad, input logic [W-1:0] a, input logic [W-1:0] b,
                                      input logic [NL-1:0] s, input logic [8:0] bl, input logic [8:0] br,
                                      output logic [W-1:0] r, output logic [NL-1:0] so);
        r  = '0;
        so = '0;
        if (!pad) begin
            r  = a + b;
            so = s;
            return;
        end
        for (int k = 0; k < NL; k++) begin
            logic fl, fr;
            logic [8:0] lv, rv, av;
            fl = 1'b0; fr = 1'b0; lv = '0; rv = '0;
            if (s[k]) begin
                r[k*8 +: 8] = a[k*8 +: 8];
                so[k] = 1'b1;
                continue;
            end
            for (int j = k-1; j >= 0; j--)
                if (!fl && s[j]) begin fl = 1'b1; lv = {1'b0, a[j*8 +: 8]}; end
            if (!fl && bl[8]) begin fl = 1'b1; lv = {1'b0, bl[7:0]}; end
            for (int j = k+1; j < NL; j++)
                if (!fr && s[j]) begin fr = 1'b1; rv = {1'b0, a[j*8 +: 8]}; end
            if (!fr && br[8]) begin fr = 1'b1; rv = {1'b0, br[7:0]}; end
            av = lv + rv;
            if (fl && fr)  r[k*8 +: 8] = av[8:1];
            else if (fl)   r[k*8 +: 8] = lv[7:0];
            else if (fr)   r[k*8 +: 8] = rv[7:0];
            else           r[k*8 +: 8] = a[k*8 +: 8];
            so[k] = fl | fr;
        end
    endfunction

    // Two-deep expected pipeline matching the two-cycle latency (R2).
    logic [W-1:0]  p1_r = '0, p2_r = '0;
    logic [NL-1:0] p1_s = '0, p2_s = '0;
    logic          p1_pad = 1'b0, p2_pad = 1'b0;
    string         p1_t = "R1", p2_t = "R1";

    task automatic compare(input logic [W-1:0] er, input logic [NL-1:0] es,
                           input logic epad, input string tag);
        n_chk++;
        if (res_out !== er) begin
            n_err++;
            $display("FAIL %s result: got %h expected %h", tag, res_out, er);
        end
        n_chk++;
        if (shape_out !== es) begin
            n_err++;
            $display("FAIL %s mask: got %b expected %b", epad ? "R9" : "R3", shape_out, es);
        end
    endtask

    task automatic step(input logic pad, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [NL-1:0] s, input logic [8:0] bl, input logic [8:0] br,
                        input string tag);
        logic [W-1:0]  er;
        logic [NL-1:0] es;
        @(negedge clk);
        compare(p2_r, p2_s, p2_pad, p2_t);
        p2_r = p1_r; p2_s = p1_s; p2_pad = p1_pad; p2_t = p1_t;
        pad_model(pad, a, b, s, bl, br, er, es);
        p1_r = er; p1_s = es; p1_pad = pad; p1_t = tag;
        pad_en = pad; op_a = a; op_b = b; shape_in = s; bnd_left = bl; bnd_right = br;
    endtask

    function automatic logic [W-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [8:0] rnd_edge();
        logic [31:0] v;
        v = $urandom;
        return v[8:0];
    endfunction

    initial begin : watchdog
        #(20ns * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd2468));

        // R1: outputs cleared and held during reset, despite busy inputs.
        repeat (3) @(negedge clk);
        pad_en = 1'b1; op_a = rnd_word(); op_b = rnd_word(); shape_in = 8'h5A;
        bnd_left = 9'h1FF; bnd_right = 9'h1FF;
        repeat (3) @(negedge clk);
        n_chk++;
        if (res_out !== '0 || shape_out !== '0) begin
            n_err++;
            $display("FAIL R1 reset: got %h/%b expected 0/0", res_out, shape_out);
        end
        pad_en = 1'b0; op_a = '0; op_b = '0; shape_in = '0; bnd_left = '0; bnd_right = '0;
        rst = 1'b0;

        // R3: carry across every byte, and mask pass-through.
        step(0, {W{1'b1}}, 64'd1, 8'hC3, 9'h1AA, 9'h155, "R3");
        step(0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 8'h0F, '0, '0, "R3");
        // R4: full mask keeps every pixel.
        step(1, 64'h0123_4567_89AB_CDEF, rnd_word(), 8'hFF, 9'h1EE, 9'h111, "R4");
        // R5: empty line, unflagged edges, keeps original pixels.
        step(1, 64'h1122_3344_5566_7788, rnd_word(), 8'h00, 9'h000, 9'h000, "R5");
        // R6: single object at lane 3 fills the whole line.
        step(1, 64'h9999_9999_5A99_9999, rnd_word(), 8'h08, 9'h000, 9'h000, "R6");
        // R6: object only at lane 0, fill runs right.
        step(1, 64'h0000_0000_0000_0042, rnd_word(), 8'h01, 9'h000, 9'h000, "R6");
        // R7: averages at the top of the range.
        step(1, 64'hFF00_0000_0000_00FF, rnd_word(), 8'h81, 9'h000, 9'h000, "R7");
        step(1, 64'hFE00_0000_0000_00FF, rnd_word(), 8'h81, 9'h000, 9'h000, "R7");
        step(1, 64'h0100_0000_0000_0000, rnd_word(), 8'h80, 9'h000, 9'h000, "R7");
        // R8: flagged edges only, middle lanes get their average 0x80.
        step(1, 64'h0, rnd_word(), 8'h00, 9'h140, 9'h1C0, "R8");
        // R8: unflagged edges with nonzero pixels are ignored.
        step(1, 64'h0807_0605_0403_0201, rnd_word(), 8'h00, 9'h0FF, 9'h0AB, "R8");
        step(1, 64'h0807_0605_0403_0201, rnd_word(), 8'h10, 9'h0FF, 9'h0AB, "R8");
        // R10: same padding job with two different op_b values.
        step(1, 64'h3000_2000_1000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'h4A, 9'h177, 9'h000, "R10");
        step(1, 64'h3000_2000_1000_0000, 64'h0, 8'h4A, 9'h177, 9'h000, "R10");
        // R2: back-to-back alternating modes.
        for (int i = 0; i < 8; i++)
            step(i[0], rnd_word(), rnd_word(), 8'(i * 37), rnd_edge(), rnd_edge(), "R2");

        // R6/R7/R9: every mask, random pixels and edges.
        for (int m = 0; m < 256; m++)
            step(1, rnd_word(), rnd_word(), 8'(m), rnd_edge(), rnd_edge(), "R6");

        // Mixed random stream; sparse masks give longer gaps.
        for (int i = 0; i < 400; i++) begin
            logic pd;
            pd = ($urandom % 4) != 0;
            step(pd, rnd_word(), rnd_word(), 8'($urandom & $urandom), rnd_edge(), rnd_edge(),
                 pd ? "R10" : "R3");
        end

        // Flush the pipeline.
        step(0, '0, '0, '0, '0, '0, "R3");
        step(0, '0, '0, '0, '0, '0, "R3");
        step(0, '0, '0, '0, '0, '0, "R3");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule